// File: doc/BRIEF.md
# Power-on vector self-test sequencer

After reset, this block holds the application logic in a test mode. In that mode it replays a stored set of test vectors and checks the responses before normal operation is allowed. The vectors come from external nonvolatile storage, one 16-bit word per read. Each input vector may be wider than one word. The block assembles it word by word in a shadow register. It then moves the whole vector to the drive register in a single cycle, so that every input of the logic under test changes on the same edge.

After a programmable settle time, the block compares the observed response with the stored expected response. If every vector matches, the block releases the inputs to the functional path. The first mismatch stops the run. The block then holds a fail flag and the index of the failing vector until the next reset.

Storage layout, in 16-bit words:
- Word 0 holds the vector count.
- Record k starts at word 1 + k·(IN_WORDS + OUT_WORDS).
- Each record holds the input vector, least significant word first, padded to whole words, followed by the expected response words in the same order.
- With the default 48-bit input and 16-bit output, a record is four words long.

Top module: `pwrup_vec_selftest`

## Requirements
- R1: While reset is asserted, and right after it, `test_mode` is 1, `test_pass` and `test_fail` are 0, `mem_rd_req` is 0 and `lut_in` is all zeros. Reset asserts asynchronously and is released on a clock edge.
- R2: The first read is word address 0 and returns the vector count N. After it, words are read once each at ascending addresses in the record layout above, with the input words least significant first. A passing run makes exactly 1 + N·(IN_WORDS + OUT_WORDS) reads.
- R3: `mem_rd_req` stays high with `mem_addr` stable until `mem_rd_valid` is seen high. The word is taken in that cycle, and only one read is outstanding at a time.
- R4: While `test_mode` is 1, `lut_in` changes only as a whole. Every new value is a complete stored input vector, and the vectors appear in storage order.
- R5: The response is sampled on the clock edge `settle_cycles`+1 cycles after the edge that updates the drive register.
- R6: When all N vectors match, `test_pass` rises, `test_mode` falls and `lut_in` follows `app_in`.
- R7: On the first mismatch, `test_fail` rises and `fail_index` gives the 0-based index of that vector. Reads stop, and `test_fail`, `test_mode` and `fail_index` hold until reset.
- R8: A vector count of 0 gives pass right after the header read, with no other read.
- R9: `test_pass` and `test_fail` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| settle_cycles | input | SETTLE_W | Wait cycles between the drive update and the compare |
| mem_addr | output | ADDR_W | Word address of the current read |
| mem_rd_req | output | 1 | Read request, held until the data is returned |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 16 | Read data word |
| app_in | input | IN_W | Functional input vector from the application |
| lut_in | output | IN_W | Inputs to the logic under test (test vector or `app_in`) |
| lut_resp | input | OUT_W | Observed response of the logic under test |
| test_mode | output | 1 | High while self-test owns the inputs |
| test_pass | output | 1 | All vectors matched |
| test_fail | output | 1 | A vector mismatched |
| fail_index | output | 16 | Index of the failing vector (0 when not failed) |

## Verification
The drive register updates on the edge after the last expected word is accepted. The response is then sampled `settle_cycles`+1 edges later. The bench's model of the logic under test has a three-register response pipeline, so a settle of 3 passes and a settle of 2 fails on vector 0. That pins the compare edge to within one cycle.

Each read completes one cycle after the request when there are no wait states. Pass or fail appears one edge after the compare. The bench therefore waits on the status outputs and samples on the falling edge. It takes every `lut_in` change at a falling edge and checks it against the table in order, and it counts the reads in the memory model.

// File: rtl/pvst_pkg.sv
package pvst_pkg;
  localparam int unsigned WORD_W = 16;

  typedef enum logic [2:0] {
    ST_HDR    = 3'd0,
    ST_LDIN   = 3'd1,
    ST_LDEXP  = 3'd2,
    ST_APPLY  = 3'd3,
    ST_SETTLE = 3'd4,
    ST_PASS   = 3'd5,
    ST_FAIL   = 3'd6
  } seq_state_t;
endpackage

// File: rtl/pvst_rst_sync.sv
module pvst_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/pvst_stage.sv
module pvst_stage #(
  parameter int unsigned IN_W  = 48,
  parameter int unsigned WORDS = (IN_W + 15) / 16,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [15:0]      wr_data,
  input  logic             xfer,
  output logic [IN_W-1:0]  drive_o
);
  localparam int unsigned PAD_W = WORDS * 16;

  logic [PAD_W-1:0] shadow_q;

  // one 16-bit lane per storage word
  for (genvar w = 0; w < WORDS; w++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow_q[w*16 +: 16] <= '0;
      end else if (wr_en && (wr_sel == SEL_W'(w))) begin
        shadow_q[w*16 +: 16] <= wr_data;
      end
    end
  end

  // output register: every bit loads on the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    drive_o <= '0;
    else if (xfer) drive_o <= shadow_q[IN_W-1:0];
  end

  // R4: drive only moves on the cycle after a transfer request
  p_drive_atomic_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drive_o) |-> $past(xfer));
endmodule

// File: rtl/pwrup_vec_selftest.sv
module pwrup_vec_selftest #(
  parameter int unsigned IN_W     = 48,
  parameter int unsigned OUT_W    = 16,
  parameter int unsigned ADDR_W   = 17,
  parameter int unsigned SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_rd_req,
  input  logic                mem_rd_valid,
  input  logic [15:0]         mem_rd_data,
  input  logic [IN_W-1:0]     app_in,
  output logic [IN_W-1:0]     lut_in,
  input  logic [OUT_W-1:0]    lut_resp,
  output logic                test_mode,
  output logic                test_pass,
  output logic                test_fail,
  output logic [15:0]         fail_index
);
  import pvst_pkg::*;

  localparam int unsigned IN_WORDS  = (IN_W + WORD_W - 1) / WORD_W;
  localparam int unsigned OUT_WORDS = (OUT_W + WORD_W - 1) / WORD_W;
  localparam int unsigned MAX_WORDS = (IN_WORDS > OUT_WORDS) ? IN_WORDS : OUT_WORDS;
  localparam int unsigned SEL_W     = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;
  localparam int unsigned EXP_W     = OUT_WORDS * WORD_W;

  logic rst_sn;

  pvst_rst_sync u_rst (
    .clk        (clk),
    .rst_ni     (rst_n),
    .rst_sync_no(rst_sn)
  );

  seq_state_t           state_q, state_d;
  logic [ADDR_W-1:0]    addr_q, addr_d;
  logic                 req_q, req_d;
  logic [SEL_W-1:0]     wcnt_q, wcnt_d;
  logic [15:0]          nvec_q, nvec_d;
  logic [15:0]          vidx_q, vidx_d;
  logic [SETTLE_W-1:0]  settle_q, settle_d;
  logic [EXP_W-1:0]     exp_q;
  logic [IN_W-1:0]      drive;
  logic                 accept, fetching, resp_match;

  assign accept     = req_q & mem_rd_valid;
  assign fetching   = (state_q == ST_HDR) || (state_q == ST_LDIN) || (state_q == ST_LDEXP);
  assign resp_match = (exp_q[OUT_W-1:0] == lut_resp);

  pvst_stage #(
    .IN_W (IN_W),
    .WORDS(IN_WORDS),
    .SEL_W(SEL_W)
  ) u_stage (
    .clk    (clk),
    .rst_n  (rst_sn),
    .wr_en  (accept && (state_q == ST_LDIN)),
    .wr_sel (wcnt_q),
    .wr_data(mem_rd_data),
    .xfer   (state_q == ST_APPLY),
    .drive_o(drive)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    addr_d   = accept ? addr_q + ADDR_W'(1) : addr_q;
    req_d    = fetching && !accept;
    wcnt_d   = wcnt_q;
    nvec_d   = nvec_q;
    vidx_d   = vidx_q;
    settle_d = settle_q;
    unique case (state_q)
      ST_HDR: if (accept) begin
        nvec_d  = mem_rd_data;
        state_d = (mem_rd_data == 16'd0) ? ST_PASS : ST_LDIN;
      end
      ST_LDIN: if (accept) begin
        if (wcnt_q == SEL_W'(IN_WORDS - 1)) begin
          wcnt_d  = '0;
          state_d = ST_LDEXP;
        end else begin
          wcnt_d = wcnt_q + SEL_W'(1);
        end
      end
      ST_LDEXP: if (accept) begin
        if (wcnt_q == SEL_W'(OUT_WORDS - 1)) begin
          wcnt_d  = '0;
          state_d = ST_APPLY;
        end else begin
          wcnt_d = wcnt_q + SEL_W'(1);
        end
      end
      ST_APPLY: begin
        settle_d = settle_cycles;
        state_d  = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (settle_q != '0) begin
          settle_d = settle_q - SETTLE_W'(1);
        end else if (!resp_match) begin
          state_d = ST_FAIL;
        end else begin
          vidx_d  = vidx_q + 16'd1;
          state_d = (vidx_q + 16'd1 == nvec_q) ? ST_PASS : ST_LDIN;
        end
      end
      default: ;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q  <= ST_HDR;
      addr_q   <= '0;
      req_q    <= 1'b0;
      wcnt_q   <= '0;
      nvec_q   <= '0;
      vidx_q   <= '0;
      settle_q <= '0;
    end else begin
      state_q  <= state_d;
      addr_q   <= addr_d;
      req_q    <= req_d;
      wcnt_q   <= wcnt_d;
      nvec_q   <= nvec_d;
      vidx_q   <= vidx_d;
      settle_q <= settle_d;
    end
  end

  // expected-response register, written one word at a time
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      exp_q <= '0;
    end else if (accept && (state_q == ST_LDEXP)) begin
      exp_q[wcnt_q*WORD_W +: WORD_W] <= mem_rd_data;
    end
  end

  assign mem_addr   = addr_q;
  assign mem_rd_req = req_q;
  assign test_mode  = (state_q != ST_PASS);
  assign test_pass  = (state_q == ST_PASS);
  assign test_fail  = (state_q == ST_FAIL);
  assign fail_index = test_fail ? vidx_q : 16'd0;
  assign lut_in     = test_mode ? drive : app_in;

  // R3: a request is held with a stable address until it is answered
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_addr)));

  // R7: fail is sticky, holds its index and issues no further reads
  p_fail_sticky_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    test_fail |=> (test_fail && $stable(fail_index) && !mem_rd_req));

  // R6: the functional path is released only after pass
  p_release_pass_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    !test_mode |-> test_pass);

  // R9: pass and fail are mutually exclusive
  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    !(test_pass && test_fail));
endmodule

// File: tb/pwrup_vec_selftest_tb.sv
module pwrup_vec_selftest_tb_top;
  localparam int IN_W = 48;
  localparam int OUT_W = 16;
  localparam int REC = 4;
  localparam int NV = 6;
  localparam logic [47:0] VEC [NV] = '{
    48'h0000_0000_0001, 48'hFFFF_0000_FFFF, 48'h1234_5678_9ABC,
    48'h8000_0000_8001, 48'hDEAD_BEEF_0F0F, 48'h5555_AAAA_3C3C
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] settle_cycles = 8'd4;
  logic [16:0] mem_addr;
  logic mem_rd_req, mem_rd_valid;
  logic [15:0] mem_rd_data;
  logic [IN_W-1:0] app_in = 48'hCAFE_F00D_1357;
  logic [IN_W-1:0] lut_in;
  logic [OUT_W-1:0] lut_resp;
  logic test_mode, test_pass, test_fail;
  logic [15:0] fail_index;

  int checks = 0, failures = 0;
  logic [15:0] mem [0:63];
  int lat = 0, lcnt = 0, reads = 0;
  logic [47:0] obs [0:15];
  int nobs = 0;
  logic [47:0] prev = '0;
  logic [15:0] p1, p2, p3;

  always #2.5 clk = ~clk;

  pwrup_vec_selftest dut_i (
    .clk(clk), .rst_n(rst_n), .settle_cycles(settle_cycles),
    .mem_addr(mem_addr), .mem_rd_req(mem_rd_req), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .app_in(app_in), .lut_in(lut_in),
    .lut_resp(lut_resp), .test_mode(test_mode), .test_pass(test_pass),
    .test_fail(test_fail), .fail_index(fail_index)
  );

  function automatic logic [15:0] lut_fn(input logic [47:0] x);
    return x[15:0] ^ {x[23:16], x[31:24]} ^ x[47:32] ^ 16'hA5C3;
  endfunction

  // model of the logic under test: three register stages of latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin p1 <= '0; p2 <= '0; p3 <= '0; end
    else begin p1 <= lut_fn(lut_in); p2 <= p1; p3 <= p2; end
  end
  assign lut_resp = p3;

  // storage model with a programmable number of wait states
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rd_valid <= 1'b0; mem_rd_data <= '0; lcnt <= 0; reads <= 0;
    end else if (!mem_rd_req || mem_rd_valid) begin
      mem_rd_valid <= 1'b0; lcnt <= 0;
    end else if (lcnt == lat) begin
      mem_rd_valid <= 1'b1; mem_rd_data <= mem[mem_addr[5:0]];
      lcnt <= 0; reads <= reads + 1;
    end else begin
      lcnt <= lcnt + 1;
    end
  end

  // record each whole-vector change seen at the inputs during test
  always @(negedge clk) begin
    if (rst_n && test_mode && lut_in !== prev && nobs < 16) begin
      obs[nobs] = lut_in;
      nobs = nobs + 1;
    end
    prev = lut_in;
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load(input int n, input int bad);
    for (int i = 0; i < 64; i++) mem[i] = 16'h0;
    mem[0] = 16'(n);
    for (int k = 0; k < n; k++) begin
      mem[1+REC*k]   = VEC[k][15:0];
      mem[1+REC*k+1] = VEC[k][31:16];
      mem[1+REC*k+2] = VEC[k][47:32];
      mem[1+REC*k+3] = lut_fn(VEC[k]) ^ ((k == bad) ? 16'h0100 : 16'h0);
    end
  endtask

  task automatic run(input int n, input int bad, input int st, input int l);
    @(negedge clk);
    rst_n = 1'b0;
    load(n, bad);
    settle_cycles = 8'(st);
    lat = l;
    nobs = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if (test_pass || test_fail) break;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset state, held and just after release
    load(NV, -1);
    repeat (3) @(negedge clk);
    chk(test_mode === 1'b1, "R1 test_mode in reset", 64'(test_mode), 64'd1);
    chk(!test_pass && !test_fail, "R1 status in reset", {test_pass, test_fail}, 0);
    chk(mem_rd_req === 1'b0, "R1 req in reset", 64'(mem_rd_req), 0);
    chk(lut_in === '0, "R1 lut_in in reset", 64'(lut_in), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_rd_req === 1'b0 && test_mode, "R1 after release", 64'(mem_rd_req), 0);

    // full pass: table of vectors walked in storage order
    run(NV, -1, 4, 0);
    chk(test_pass === 1'b1, "R6 pass", 64'(test_pass), 1);
    chk(test_mode === 1'b0, "R6 test_mode low", 64'(test_mode), 0);
    chk(lut_in === app_in, "R6 lut_in follows app_in", 64'(lut_in), 64'(app_in));
    chk(reads == 1 + NV*REC, "R2 read count", 64'(reads), 64'(1 + NV*REC));
    chk(nobs == NV, "R4 vector changes", 64'(nobs), NV);
    for (int k = 0; k < NV; k++)
      chk(obs[k] === VEC[k], $sformatf("R4 vector %0d applied whole", k), 64'(obs[k]), 64'(VEC[k]));
    app_in = 48'h0123_4567_89AB;
    @(negedge clk);
    chk(lut_in === app_in, "R6 lut_in tracks app_in change", 64'(lut_in), 64'(app_in));

    // mismatch at vector 3: stop, hold index, stay in test mode
    run(NV, 3, 4, 0);
    chk(test_fail === 1'b1 && test_pass === 1'b0, "R7 fail flag", {test_pass, test_fail}, 1);
    chk(fail_index == 16'd3, "R7 fail index", 64'(fail_index), 3);
    chk(reads == 1 + 4*REC, "R7 reads up to failing record", 64'(reads), 64'(1 + 4*REC));
    begin
      int r0;
      r0 = reads;
      repeat (20) @(negedge clk);
      chk(reads == r0 && !mem_rd_req, "R7 no reads after fail", 64'(reads), 64'(r0));
      chk(test_fail && test_mode && fail_index == 16'd3, "R7 sticky", 64'(fail_index), 3);
      chk(lut_in === VEC[3], "R7 inputs hold failing vector", 64'(lut_in), 64'(VEC[3]));
    end

    // zero vectors: pass after the header alone
    run(0, -1, 4, 0);
    chk(test_pass === 1'b1, "R8 pass on zero count", 64'(test_pass), 1);
    chk(reads == 1, "R8 header read only", 64'(reads), 1);

    // settle boundary against the three-cycle response path
    run(NV, -1, 2, 0);
    chk(test_fail === 1'b1 && fail_index == 16'd0, "R5 settle 2 too short", 64'(fail_index), 0);
    run(NV, -1, 3, 0);
    chk(test_pass === 1'b1, "R5 settle 3 enough", 64'(test_pass), 1);

    // slow storage: wait states do not disturb the sequence
    run(NV, -1, 3, 3);
    chk(test_pass === 1'b1, "R3 pass with wait states", 64'(test_pass), 1);
    chk(reads == 1 + NV*REC, "R3 one read per word", 64'(reads), 64'(1 + NV*REC));
    chk(!(test_pass && test_fail), "R9 exclusive", {test_pass, test_fail}, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule